// File: doc/BRIEF.md
# Rotating-Priority Interrupt Controller Core

This block arbitrates eight interrupt request lines for one processor. It keeps three line-wide registers: the requests it has seen, a mask that hides lines from arbitration, and the in-service set that records which interrupts the processor is still handling. A priority resolver ranks lines starting from a stored offset, so the highest-priority position can be moved around the eight lines. The block raises `int_valid` and names the winning line whenever the best unmasked request ranks strictly above everything in service. The processor pulses `ack` to take that line.

Software drives the block through a two-address byte bus. A control write to address 0 can do one of three things. It can start the initialization sequence, which then continues through address 1. It can send an operation word that arms poll mode or chooses which register address 0 reads back. Otherwise it issues an end-of-interrupt or rotation command. In normal running, writes to address 1 load the mask. Reads return the mask, the request register or the in-service register. In poll mode a read returns the pending line instead of a register. The block also holds the vector base given at initialization, on `vec_base`, for the vector logic that follows it.

Top module: `rot_prio_intc`

## Requirements
- R1: After reset the request, in-service and mask registers, the offset and `rdata` are all zero, `vec_base` is zero, the read select points at the request register, and `int_valid` is low.
- R2: A bit of `req_in` that is high at a clock edge sets the matching request bit at that edge. The bit stays set until an acknowledge or a poll read of that line clears it. If a clear and `req_in` land on the same edge, the clear wins.
- R3: `int_line` names the first line whose request bit is set and whose mask bit is clear, scanning lines offset, offset+1, ... modulo 8. After reset the offset is 0, so line 0 ranks highest.
- R4: `int_valid` is high only when the winning line's rank (its distance from the offset) is strictly smaller than the rank of the best in-service bit. With nothing in service, any pending unmasked request is enough.
- R5: An `ack` while `int_valid` is high clears the request bit of `int_line`. Unless auto-EOI is on, it also sets that line's in-service bit. An `ack` while `int_valid` is low changes nothing.
- R6: With auto-EOI on (mode word bit 1), an accepted `ack` leaves the in-service register unchanged. If rotate-on-auto-EOI is set, the same `ack` sets the offset to the acknowledged line + 1.
- R7: A write to address 0 with bit 4 set clears the registers, the offset, the read select, poll, auto-EOI and rotate-on-auto-EOI. Bit 0 of that write records whether a mode word follows. The next writes to address 1 are, in turn: the vector base (`vec_base` = value with bits 2:0 cleared), a word with no effect, and then the mode word if one was flagged. Only after the last of these do writes to address 1 load the mask again.
- R8: In normal running a write to address 1 loads the mask. A read from address 1 returns it. A masked line never wins arbitration.
- R9: A write to address 0 with bit 4 clear and bit 3 set is an operation word. If its bit 1 is set, its bit 0 selects what address 0 reads: 1 gives the in-service register, 0 gives the request register.
- R10: A write to address 0 with bits 4 and 3 clear and bits 7:5 = 1 clears the highest-ranked in-service bit. Code 5 does the same and also sets the offset to that line + 1. Neither does anything when nothing is in service.
- R11: Code 3 clears the in-service bit named by bits 2:0. Code 7 clears it and also sets the offset to that line + 1.
- R12: Code 6 sets the offset to bits 2:0 + 1 (modulo 8). Codes 0 and 4 set rotate-on-auto-EOI to bit 7. Code 2 does nothing.
- R13: An operation word with bit 2 set arms poll mode. The next read, at either address, returns the winning line number and clears that line's request and in-service bits when `int_valid` is high, or returns 7 when it is low. That read disarms poll mode.
- R14: `rdata` changes only at a clock edge where `rd_en` is high. It shows the read result from the next cycle on and holds it until the next read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | NUM_LINES (8) | Interrupt request lines, sampled every edge |
| ack | input | 1 | Processor takes the line shown on `int_line` |
| wr_en | input | 1 | Bus write strobe |
| rd_en | input | 1 | Bus read strobe |
| addr | input | 1 | Bus address: 0 control/status, 1 data/mask |
| wdata | input | 8 | Bus write data |
| rdata | output | 8 | Registered bus read data |
| int_valid | output | 1 | An interrupt should be raised to the processor |
| int_line | output | log2(NUM_LINES) (3) | Winning line number |
| vec_base | output | 8 | Vector base from initialization, bits 2:0 zero |

## Verification
The resolver is driven with several request patterns. Two requests at different ranks show whether the scan order is right. A request masked off shows that the mask is honoured. A higher line arriving while a lower one is in service separates a strict rank comparison from a non-strict one. Requests on lines 0 and 7 after each offset change show whether rotation moves the scan start to line + 1 rather than to the line itself. Auto-EOI and poll sequences are run once with the rotation flag set and once with it clear, and poll reads are made both with a winner and with none. Together these separate the in-service, offset and request side effects of each path.

// File: rtl/rpic_pkg.sv
package rpic_pkg;
   localparam int BYTE_W = 8;
   localparam int CMD_W  = 3;

   // control-word bit positions (software-visible encoding)
   localparam int INIT_BIT    = 4;
   localparam int OPW_BIT     = 3;
   localparam int POLL_BIT    = 2;
   localparam int SEL_EN_BIT  = 1;
   localparam int SEL_VAL_BIT = 0;
   localparam int LONG_BIT    = 0;
   localparam int AEOI_BIT    = 1;
   localparam int ROT_BIT     = 7;

   localparam logic [BYTE_W-1:0] POLL_EMPTY = 8'h07;

   typedef enum logic [1:0] {
      ST_RUN  = 2'd0,
      ST_BASE = 2'd1,
      ST_CASC = 2'd2,
      ST_MODE = 2'd3
   } rpic_init_e;

   typedef struct packed {
      logic             init_go;
      logic             init_long;
      logic             poll_set;
      logic             sel_we;
      logic             sel_isr;
      logic             rot_we;
      logic             rot_val;
      logic             eoi_top;
      logic             eoi_named;
      logic             off_from_top;
      logic             off_from_named;
      logic [CMD_W-1:0] named;
      logic             mask_we;
      logic             base_we;
      logic             casc_we;
      logic             mode_we;
   } rpic_cmd_t;
endpackage

// File: rtl/rpic_prio_scan.sv
module rpic_prio_scan #(
   parameter int N  = 8,
   parameter int LW = $clog2(N)
) (
   input  logic [N-1:0]  vec,
   input  logic [LW-1:0] offset,
   output logic          found,
   output logic [LW-1:0] rank,
   output logic [LW-1:0] line
);
   logic [N-1:0] rot;

   // rotate so that position 0 is the line at the offset
   for (genvar i = 0; i < N; i++) begin : g_rot
      logic [LW-1:0] src;
      assign src    = LW'(i) + offset;
      assign rot[i] = vec[src];
   end

   always_comb begin
      found = |rot;
      rank  = '0;
      for (int k = N - 1; k >= 0; k--) begin
         if (rot[k]) rank = LW'(k);
      end
   end

   assign line = rank + offset;
endmodule

// File: rtl/rpic_cmd_decode.sv
module rpic_cmd_decode
   import rpic_pkg::*;
(
   input  logic              wr_en,
   input  logic              addr,
   input  logic [BYTE_W-1:0] wdata,
   input  rpic_init_e        init_st,
   output rpic_cmd_t         cmd
);
   logic [CMD_W-1:0] code;
   logic ctl_wr, data_wr, is_init, is_opw, is_ocmd;

   always_comb begin
      code    = wdata[BYTE_W-1 -: CMD_W];
      ctl_wr  = wr_en && !addr;
      data_wr = wr_en && addr;
      is_init = ctl_wr && wdata[INIT_BIT];
      is_opw  = ctl_wr && !wdata[INIT_BIT] && wdata[OPW_BIT];
      is_ocmd = ctl_wr && !wdata[INIT_BIT] && !wdata[OPW_BIT];

      cmd           = '0;
      cmd.init_go   = is_init;
      cmd.init_long = wdata[LONG_BIT];
      cmd.poll_set  = is_opw && wdata[POLL_BIT];
      cmd.sel_we    = is_opw && wdata[SEL_EN_BIT];
      cmd.sel_isr   = wdata[SEL_VAL_BIT];
      cmd.named     = wdata[CMD_W-1:0];
      cmd.rot_val   = wdata[ROT_BIT];
      cmd.mask_we   = data_wr && (init_st == ST_RUN);
      cmd.base_we   = data_wr && (init_st == ST_BASE);
      cmd.casc_we   = data_wr && (init_st == ST_CASC);
      cmd.mode_we   = data_wr && (init_st == ST_MODE);

      if (is_ocmd) begin
         case (code)
            3'd0, 3'd4: cmd.rot_we = 1'b1;
            3'd1:       cmd.eoi_top = 1'b1;
            3'd5: begin
               cmd.eoi_top      = 1'b1;
               cmd.off_from_top = 1'b1;
            end
            3'd3:       cmd.eoi_named = 1'b1;
            3'd6:       cmd.off_from_named = 1'b1;
            3'd7: begin
               cmd.eoi_named      = 1'b1;
               cmd.off_from_named = 1'b1;
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/rot_prio_intc.sv
module rot_prio_intc
   import rpic_pkg::*;
#(
   parameter int NUM_LINES = 8
) (
   input  logic                         clk,
   input  logic                         rst_n,
   input  logic [NUM_LINES-1:0]         req_in,
   input  logic                         ack,
   input  logic                         wr_en,
   input  logic                         rd_en,
   input  logic                         addr,
   input  logic [BYTE_W-1:0]            wdata,
   output logic [BYTE_W-1:0]            rdata,
   output logic                         int_valid,
   output logic [$clog2(NUM_LINES)-1:0] int_line,
   output logic [BYTE_W-1:0]            vec_base
);
   localparam int LINE_W = $clog2(NUM_LINES);
   localparam int BASE_W = BYTE_W - CMD_W;
   localparam logic [NUM_LINES-1:0] BIT0 = NUM_LINES'(1);

   if (NUM_LINES < 2 || NUM_LINES > (1 << CMD_W) || (1 << LINE_W) != NUM_LINES) begin : g_bad_lines
      $error("rot_prio_intc: NUM_LINES must be a power of two from 2 to 8");
   end

   logic [NUM_LINES-1:0] irr_q, imr_q, isr_q;
   logic [LINE_W-1:0]    off_q;
   logic [BASE_W-1:0]    base_q;
   logic                 sel_q, poll_q, aeoi_q, rot_q, long_q;
   rpic_init_e           st_q;
   logic [BYTE_W-1:0]    rdata_q;

   rpic_cmd_t            cmd;
   logic [NUM_LINES-1:0] pend;
   logic                 p_found, s_found;
   logic [LINE_W-1:0]    p_rank, s_rank, p_line, s_line, n_line;
   logic [NUM_LINES-1:0] p_bit, s_bit, n_bit;
   logic                 take, poll_take;
   logic [NUM_LINES-1:0] irr_clr, isr_set, isr_clr;
   logic [LINE_W-1:0]    off_d;
   logic [BYTE_W-1:0]    rd_d;

   rpic_cmd_decode u_dec (
      .wr_en   (wr_en),
      .addr    (addr),
      .wdata   (wdata),
      .init_st (st_q),
      .cmd     (cmd)
   );

   assign pend = irr_q & ~imr_q;

   rpic_prio_scan #(.N(NUM_LINES), .LW(LINE_W)) u_pend_scan (
      .vec    (pend),
      .offset (off_q),
      .found  (p_found),
      .rank   (p_rank),
      .line   (p_line)
   );

   rpic_prio_scan #(.N(NUM_LINES), .LW(LINE_W)) u_svc_scan (
      .vec    (isr_q),
      .offset (off_q),
      .found  (s_found),
      .rank   (s_rank),
      .line   (s_line)
   );

   assign int_valid = p_found && (!s_found || (p_rank < s_rank));
   assign int_line  = p_line;
   assign take      = ack && int_valid;
   assign poll_take = rd_en && poll_q && int_valid;
   assign n_line    = cmd.named[LINE_W-1:0];
   assign p_bit     = BIT0 << p_line;
   assign s_bit     = BIT0 << s_line;
   assign n_bit     = BIT0 << n_line;

   // clear/set vectors and offset; bus commands override the ack rotation
   always_comb begin
      irr_clr = '0;
      isr_set = '0;
      isr_clr = '0;
      off_d   = off_q;
      if (take) begin
         irr_clr = irr_clr | p_bit;
         if (aeoi_q) begin
            if (rot_q) off_d = p_line + LINE_W'(1);
         end else begin
            isr_set = p_bit;
         end
      end
      if (poll_take) begin
         irr_clr = irr_clr | p_bit;
         isr_clr = isr_clr | p_bit;
      end
      if (cmd.eoi_top && s_found) isr_clr = isr_clr | s_bit;
      if (cmd.eoi_named)          isr_clr = isr_clr | n_bit;
      if (cmd.off_from_top && s_found) off_d = s_line + LINE_W'(1);
      if (cmd.off_from_named)          off_d = n_line + LINE_W'(1);
   end

   always_comb begin
      if (poll_q)      rd_d = int_valid ? BYTE_W'(p_line) : POLL_EMPTY;
      else if (addr)   rd_d = BYTE_W'(imr_q);
      else if (sel_q)  rd_d = BYTE_W'(isr_q);
      else             rd_d = BYTE_W'(irr_q);
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         irr_q   <= '0;
         imr_q   <= '0;
         isr_q   <= '0;
         off_q   <= '0;
         base_q  <= '0;
         sel_q   <= 1'b0;
         poll_q  <= 1'b0;
         aeoi_q  <= 1'b0;
         rot_q   <= 1'b0;
         long_q  <= 1'b0;
         st_q    <= ST_RUN;
         rdata_q <= '0;
      end else begin
         if (rd_en) rdata_q <= rd_d;
         if (cmd.init_go) begin
            irr_q  <= '0;
            imr_q  <= '0;
            isr_q  <= '0;
            off_q  <= '0;
            base_q <= '0;
            sel_q  <= 1'b0;
            poll_q <= 1'b0;
            aeoi_q <= 1'b0;
            rot_q  <= 1'b0;
            long_q <= cmd.init_long;
            st_q   <= ST_BASE;
         end else begin
            irr_q <= (irr_q | req_in) & ~irr_clr;
            isr_q <= (isr_q | isr_set) & ~isr_clr;
            off_q <= off_d;
            if (cmd.mask_we) imr_q <= wdata[NUM_LINES-1:0];
            if (cmd.base_we) begin
               base_q <= wdata[BYTE_W-1:CMD_W];
               st_q   <= ST_CASC;
            end
            if (cmd.casc_we) st_q <= long_q ? ST_MODE : ST_RUN;
            if (cmd.mode_we) begin
               aeoi_q <= wdata[AEOI_BIT];
               st_q   <= ST_RUN;
            end
            if (cmd.sel_we) sel_q <= cmd.sel_isr;
            if (cmd.rot_we) rot_q <= cmd.rot_val;
            if (cmd.poll_set)  poll_q <= 1'b1;
            else if (rd_en)    poll_q <= 1'b0;
         end
      end
   end

   assign rdata    = rdata_q;
   assign vec_base = {base_q, {CMD_W{1'b0}}};
endmodule

// File: rtl/rot_prio_intc_chk.sv
module rot_prio_intc_chk #(
   parameter int N  = 8,
   parameter int LW = $clog2(N)
) (
   input logic          clk,
   input logic          rst_n,
   input logic          ack,
   input logic          wr_en,
   input logic          rd_en,
   input logic [7:0]    rdata,
   input logic          int_valid,
   input logic [LW-1:0] int_line,
   input logic [N-1:0]  irr,
   input logic [N-1:0]  imr,
   input logic [N-1:0]  isr,
   input logic          aeoi
);
   a_r3_line_is_pending: assert property (@(posedge clk) disable iff (!rst_n)
      int_valid |-> (irr[int_line] && !imr[int_line]));

   a_r4_winner_not_in_service: assert property (@(posedge clk) disable iff (!rst_n)
      int_valid |-> !isr[int_line]);

   a_r5_ack_clears_request: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && int_valid) |=> !irr[$past(int_line)]);

   a_r5_ack_sets_service: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && int_valid && !aeoi && !wr_en && !rd_en) |=> isr[$past(int_line)]);

   a_r6_auto_eoi_keeps_service: assert property (@(posedge clk) disable iff (!rst_n)
      (ack && aeoi && !wr_en && !rd_en) |=> $stable(isr));

   a_r8_mask_needs_write: assert property (@(posedge clk) disable iff (!rst_n)
      !wr_en |=> $stable(imr));

   a_r14_rdata_holds: assert property (@(posedge clk) disable iff (!rst_n)
      !rd_en |=> $stable(rdata));
endmodule

bind rot_prio_intc rot_prio_intc_chk #(.N(NUM_LINES)) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ack       (ack),
   .wr_en     (wr_en),
   .rd_en     (rd_en),
   .rdata     (rdata),
   .int_valid (int_valid),
   .int_line  (int_line),
   .irr       (irr_q),
   .imr       (imr_q),
   .isr       (isr_q),
   .aeoi      (aeoi_q)
);

// File: tb/rot_prio_intc_test.sv
module rot_prio_intc_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] req_in = '0;
   logic       ack = 1'b0, wr_en = 1'b0, rd_en = 1'b0, addr = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata;
   logic       int_valid;
   logic [2:0] int_line;
   logic [7:0] vec_base;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #10 clk = ~clk;

   rot_prio_intc #(.NUM_LINES(8)) uut (
      .clk(clk), .rst_n(rst_n), .req_in(req_in), .ack(ack),
      .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
      .rdata(rdata), .int_valid(int_valid), .int_line(int_line),
      .vec_base(vec_base)
   );

   // ---------------- behavioural reference ----------------
   bit [7:0] m_irr, m_imr, m_isr, m_rdata, m_base;
   int       m_off, m_st;
   bit       m_sel, m_poll, m_aeoi, m_rot, m_long;

   function automatic int rank_of(bit [7:0] v, int off);
      for (int i = 0; i < 8; i++) if (v[(i + off) % 8]) return i;
      return 8;
   endfunction

   function automatic bit m_valid();
      int pr = rank_of(m_irr & ~m_imr, m_off);
      int sr = rank_of(m_isr, m_off);
      return (pr < 8) && (pr < sr);
   endfunction

   function automatic int m_line();
      return (rank_of(m_irr & ~m_imr, m_off) + m_off) % 8;
   endfunction

   always @(posedge clk) begin : model_step
      int pr, sr, pl, sl, noff, code;
      bit v;
      bit [7:0] clr, iset, iclr, w;
      if (!rst_n) begin
         m_irr = 0; m_imr = 0; m_isr = 0; m_rdata = 0; m_base = 0;
         m_off = 0; m_st = 0; m_sel = 0; m_poll = 0; m_aeoi = 0; m_rot = 0; m_long = 0;
      end else begin
         w = wdata;
         code = int'(w[7:5]);
         pr = rank_of(m_irr & ~m_imr, m_off);
         sr = rank_of(m_isr, m_off);
         v  = (pr < 8) && (pr < sr);
         pl = (pr + m_off) % 8;
         sl = (sr + m_off) % 8;
         clr = 0; iset = 0; iclr = 0; noff = m_off;
         if (ack && v) begin
            clr[pl] = 1'b1;
            if (m_aeoi) begin
               if (m_rot) noff = (pl + 1) % 8;
            end else iset[pl] = 1'b1;
         end
         if (rd_en) begin
            if (m_poll) begin
               if (v) begin
                  m_rdata = 8'(pl); clr[pl] = 1'b1; iclr[pl] = 1'b1;
               end else m_rdata = 8'h07;
            end else if (addr) m_rdata = m_imr;
            else m_rdata = m_sel ? m_isr : m_irr;
            m_poll = 1'b0;
         end
         if (wr_en && !addr && w[4]) begin
            m_irr = 0; m_imr = 0; m_isr = 0; m_base = 0; m_off = 0;
            m_sel = 0; m_poll = 0; m_aeoi = 0; m_rot = 0;
            m_long = w[0]; m_st = 1;
         end else begin
            if (wr_en && !addr && w[3]) begin
               if (w[2]) m_poll = 1'b1;
               if (w[1]) m_sel = w[0];
            end else if (wr_en && !addr) begin
               case (code)
                  0, 4: m_rot = w[7];
                  1: if (sr < 8) iclr[sl] = 1'b1;
                  5: if (sr < 8) begin iclr[sl] = 1'b1; noff = (sl + 1) % 8; end
                  3: iclr[w[2:0]] = 1'b1;
                  6: noff = (int'(w[2:0]) + 1) % 8;
                  7: begin iclr[w[2:0]] = 1'b1; noff = (int'(w[2:0]) + 1) % 8; end
                  default: ;
               endcase
            end
            if (wr_en && addr) begin
               case (m_st)
                  0: m_imr = w;
                  1: begin m_base = w & 8'hF8; m_st = 2; end
                  2: m_st = m_long ? 3 : 0;
                  default: begin m_aeoi = w[1]; m_st = 0; end
               endcase
            end
            m_irr = (m_irr | req_in) & ~clr;
            m_isr = (m_isr | iset) & ~iclr;
            m_off = noff;
         end
      end
   end

   task automatic check(input int act, input int exp, input string tag);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: got 0x%0h expected 0x%0h", tag, act, exp);
      end
   endtask

   // compare against the reference every cycle, away from the active edge
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(int_valid, m_valid(), "R4 int_valid vs reference");
         if (m_valid()) check(int_line, m_line(), "R3 int_line vs reference");
         check(rdata, m_rdata, "R14 rdata vs reference");
         check(vec_base, m_base, "R7 vec_base vs reference");
      end
   end

   // ---------------- stimulus helpers ----------------
   task automatic cyc(input bit w, input bit r, input bit a, input bit k, input logic [7:0] d);
      @(negedge clk);
      wr_en = w; rd_en = r; addr = a; ack = k; wdata = d;
      @(negedge clk);
      wr_en = 1'b0; rd_en = 1'b0; ack = 1'b0;
   endtask

   task automatic wr(input bit a, input logic [7:0] d);
      cyc(1'b1, 1'b0, a, 1'b0, d);
   endtask

   task automatic ackc();
      cyc(1'b0, 1'b0, 1'b0, 1'b1, 8'h00);
   endtask

   task automatic expect_rd(input bit a, input int exp, input string tag);
      cyc(1'b0, 1'b1, a, 1'b0, 8'h00);
      check(rdata, exp, tag);
   endtask

   task automatic pulse(input logic [7:0] v);
      @(negedge clk); req_in = v;
      @(negedge clk); req_in = '0;
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         checks++; errors++;
         $display("FAIL watchdog: got timeout expected completion");
         finish_run();
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      // R1 reset state
      check(int_valid, 0, "R1 int_valid after reset");
      check(rdata, 0, "R1 rdata after reset");
      check(vec_base, 0, "R1 vec_base after reset");
      expect_rd(1'b1, 8'h00, "R1 mask after reset");
      expect_rd(1'b0, 8'h00, "R1 request after reset");

      // R2 / R3 requests latch, line 2 beats line 5
      pulse(8'h24);
      expect_rd(1'b0, 8'h24, "R2 request register");
      check(int_valid, 1, "R3 valid with pending");
      check(int_line, 2, "R3 fixed priority after reset");

      // R8 mask
      wr(1'b1, 8'h04);
      check(int_line, 5, "R8 masked line skipped");
      expect_rd(1'b1, 8'h04, "R8 mask readback");
      wr(1'b1, 8'h00);
      check(int_line, 2, "R3 line 2 again");

      // R5 acknowledge, R9 read select, R4 blocking
      ackc();
      wr(1'b0, 8'h0B);
      expect_rd(1'b0, 8'h04, "R5 R9 in-service after ack");
      check(int_valid, 0, "R4 lower rank blocked by service");
      wr(1'b0, 8'h0A);
      expect_rd(1'b0, 8'h20, "R5 R9 request cleared by ack");
      wr(1'b0, 8'h0B);

      pulse(8'h01);
      check(int_valid, 1, "R4 higher rank preempts");
      check(int_line, 0, "R4 preempting line");
      ackc();
      check(int_valid, 0, "R4 blocked after nested ack");
      expect_rd(1'b0, 8'h05, "R5 nested service bits");

      // R10 non-specific EOI
      wr(1'b0, 8'h20);
      expect_rd(1'b0, 8'h04, "R10 non-specific EOI clears top");
      // R11 specific EOI on line 2
      wr(1'b0, 8'h62);
      expect_rd(1'b0, 8'h00, "R11 specific EOI");
      check(int_valid, 1, "R11 line 5 released");
      check(int_line, 5, "R11 line 5 wins");
      ackc();

      // R10 rotating non-specific EOI: offset becomes 6
      wr(1'b0, 8'hA0);
      expect_rd(1'b0, 8'h00, "R10 rotating EOI clears");
      pulse(8'h81);
      check(int_line, 7, "R10 offset moved to line+1");

      // R12 set priority
      wr(1'b0, 8'hC7);
      check(int_line, 0, "R12 offset 0");
      wr(1'b0, 8'hC0);
      check(int_line, 7, "R12 offset 1");

      // R11 specific rotate (code 7)
      ackc();
      check(int_valid, 0, "R4 line 0 ranks last");
      wr(1'b0, 8'hE7);
      check(int_valid, 1, "R11 code 7 releases");
      check(int_line, 0, "R11 code 7 rotates offset");

      // R13 poll
      pulse(8'h40);
      wr(1'b1, 8'h01);
      wr(1'b0, 8'h0C);
      expect_rd(1'b0, 8'h06, "R13 poll returns line");
      wr(1'b0, 8'h0A);
      expect_rd(1'b0, 8'h01, "R13 polled request cleared");
      check(int_valid, 0, "R13 nothing left pending");
      wr(1'b0, 8'h0C);
      expect_rd(1'b1, 8'h07, "R13 empty poll");
      expect_rd(1'b1, 8'h01, "R13 poll disarmed");

      // R5 ack with nothing valid
      ackc();
      wr(1'b0, 8'h0B);
      expect_rd(1'b0, 8'h00, "R5 idle ack ignored");

      // R7 short init
      wr(1'b0, 8'h10);
      check(int_valid, 0, "R7 init clears");
      wr(1'b1, 8'h2F);
      wr(1'b1, 8'h55);
      wr(1'b1, 8'h33);
      check(vec_base, 8'h28, "R7 vector base");
      expect_rd(1'b1, 8'h33, "R7 mask after short init");
      expect_rd(1'b0, 8'h00, "R7 request cleared by init");
      // R14 hold
      expect_rd(1'b1, 8'h33, "R14 read");
      wr(1'b1, 8'h44);
      check(rdata, 8'h33, "R14 holds without read");
      expect_rd(1'b1, 8'h44, "R14 updates on read");

      // R7 long init, R6 auto-EOI with rotation
      wr(1'b0, 8'h11);
      wr(1'b1, 8'h6D);
      wr(1'b1, 8'hFF);
      wr(1'b1, 8'h02);
      check(vec_base, 8'h68, "R7 vector base long init");
      expect_rd(1'b1, 8'h00, "R7 init words leave mask");
      wr(1'b0, 8'h80);
      pulse(8'h09);
      check(int_line, 0, "R6 first winner");
      ackc();
      check(int_line, 3, "R6 next winner");
      wr(1'b0, 8'h0B);
      expect_rd(1'b0, 8'h00, "R6 in-service untouched");
      ackc();
      pulse(8'h05);
      check(int_line, 0, "R6 rotation on ack");
      wr(1'b0, 8'h00);
      ackc();
      pulse(8'h01);
      check(int_line, 0, "R12 rotation disabled keeps offset");

      repeat (3) @(negedge clk);
      finish_run();
   end
endmodule